// File: doc/BRIEF.md
# ECC Error Capture Register Bank

This block sits beside a DRAM ECC checker. It records which memory error events have happened and keeps the details of one ECC error for software to read. Error events arrive as one-cycle pulses:

- correctable (single-bit) and uncorrectable (multi-bit) ECC errors, which come with the failing line address, the channel and an 8-bit syndrome;
- refresh timeout;
- a locked access that targets non-DRAM memory;
- thermal sensor trip.

Each event sets a sticky flag in a 16-bit status register. Software clears a flag by writing a 1 to it. A 16-bit enable register uses the same bit layout and chooses which flags drive the level-sensitive system-error output.

Only one ECC error is logged at a time, and an uncorrectable error has priority. The first ECC error that arrives while both ECC flags are clear loads the log. An uncorrectable error that arrives while only the correctable flag is set replaces the logged details. Any other ECC error leaves the log frozen until software clears both ECC flags.

Registers are reached through a 3-bit select with a 16-bit write port and a combinational 32-bit read port.

Top module: `ecc_err_log`

## Requirements
- R1: After reset every register reads 0 and `sysErr` is low.
- R2: Status flag positions:
  - bit 0 is set by `ceEvt`;
  - bit 1 is set by `ueEvt`;
  - bit 8 is set by `refreshTimeout`;
  - bit 9 is set by `lockNonDram`;
  - bit 11 is set by `thermEvt`.

  Each flag is set on the clock edge where its event is high and is then held. All other status bits read 0. The status register is select 0.
- R3: Writing select 0 clears each flag whose write-data bit is 1. Flags whose write-data bit is 0 keep their value.
- R4: If a clear and a new event hit the same flag in the same cycle, the flag stays set.
- R5: Select 2 reads the address pointer: line address bits 31:7 in bits 31:7, zeros in bits 6:1, and the error channel in bit 0. Select 3 reads address bit 32 in bit 0, with all other bits 0.
- R6: Select 4 reads the logged 8-bit syndrome in bits 7:0.
- R7: An ECC error that arrives while both ECC flags are clear loads address, channel and syndrome. If both ECC errors arrive together, the uncorrectable error's details are loaded.
- R8: An uncorrectable error that arrives while only the correctable flag is set overwrites the logged details.
- R9: A correctable error while either ECC flag is set, or an uncorrectable error while the uncorrectable flag is set, leaves the logged details unchanged.
- R10: Select 1 is the system-error enable register. Only bits 0, 1, 8, 9 and 11 are stored, and the other bits read 0. `sysErr` is high exactly while some status flag and its enable bit are both 1.
- R11: Writes to selects 2, 3 and 4 have no effect. Unused selects read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ceEvt | input | 1 | Correctable ECC error pulse |
| ueEvt | input | 1 | Uncorrectable ECC error pulse |
| errLine | input | 26 | Failing physical address bits 32:7 |
| errChan | input | 1 | Channel of the failing access |
| errSyn | input | 8 | ECC syndrome of the failing access |
| refreshTimeout | input | 1 | Refresh timeout event pulse |
| lockNonDram | input | 1 | Locked access to non-DRAM memory event pulse |
| thermEvt | input | 1 | Thermal sensor event pulse |
| regSel | input | 3 | Register select |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 16 | Register write data |
| regRdData | output | 32 | Combinational read data for `regSel` |
| sysErr | output | 1 | System-error output, level |

## Verification
The bench walks the ECC log through its priority cases, and each case catches a different mistake:

- A correctable error arriving after an uncorrectable one would corrupt the log in a design that loads on every event.
- A repeated uncorrectable error would overwrite the first one's details in a design that ignores the held uncorrectable flag.
- An uncorrectable error that follows a correctable one would leave stale correctable details in a design that never lets it take over.

The bench also collides a clear with a new event on the same flag. A design that lets the clear win would drop an error. It tries a write of 0 and writes to the read-only logging selects, to catch a design that toggles flags or lets software corrupt the log. Finally, it sweeps all 32 enable combinations over the five flags and checks that `sysErr` follows each flag-and-enable pair.

// File: rtl/ecc_log_pkg.sv
package ecc_log_pkg;
  localparam int STS_W   = 16;
  localparam int BIT_CE  = 0;
  localparam int BIT_UE  = 1;
  localparam int BIT_RT  = 8;
  localparam int BIT_LK  = 9;
  localparam int BIT_TH  = 11;
  localparam logic [STS_W-1:0] FLAG_MASK = 16'h0B03;

  typedef enum logic [2:0] {
    SEL_STS = 3'd0,
    SEL_CMD = 3'd1,
    SEL_PTR = 3'd2,
    SEL_EXT = 3'd3,
    SEL_SYN = 3'd4
  } regSel_e;

  typedef struct packed {
    logic logLoad;
  } ctrlStrb_t;
endpackage

// File: rtl/ecc_log_ctrl.sv
module ecc_log_ctrl
  import ecc_log_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             ceEvt,
  input  logic             ueEvt,
  input  logic             rtEvt,
  input  logic             lkEvt,
  input  logic             thEvt,
  input  logic             wrEn,
  input  logic [2:0]       regSel,
  input  logic [STS_W-1:0] wrData,
  output logic [STS_W-1:0] sts,
  output logic [STS_W-1:0] cmd,
  output ctrlStrb_t        strb,
  output logic             sysErr
);
  logic [STS_W-1:0] evtVec;
  logic [STS_W-1:0] clrMask;
  logic             wrSts;
  logic             wrCmd;

  assign wrSts = wrEn && (regSel == SEL_STS);
  assign wrCmd = wrEn && (regSel == SEL_CMD);

  always_comb begin
    evtVec         = '0;
    evtVec[BIT_CE] = ceEvt;
    evtVec[BIT_UE] = ueEvt;
    evtVec[BIT_RT] = rtEvt;
    evtVec[BIT_LK] = lkEvt;
    evtVec[BIT_TH] = thEvt;
  end

  assign clrMask = wrSts ? wrData : '0;

  // Per-bit sticky flags and enables; reserved positions are tied to 0.
  for (genvar b = 0; b < STS_W; b++) begin : g_bit
    if (FLAG_MASK[b]) begin : g_flag
      always_ff @(posedge clk) begin
        if (!rstN) begin
          sts[b] <= 1'b0;
          cmd[b] <= 1'b0;
        end else begin
          sts[b] <= (sts[b] && !clrMask[b]) || evtVec[b];
          if (wrCmd) cmd[b] <= wrData[b];
        end
      end
    end else begin : g_rsvd
      assign sts[b] = 1'b0;
      assign cmd[b] = 1'b0;
    end
  end

  // Uncorrectable error displaces a pending correctable log; otherwise
  // the log is taken only when no ECC flag is held.
  assign strb.logLoad = (ueEvt && !sts[BIT_UE]) ||
                        (ceEvt && !sts[BIT_CE] && !sts[BIT_UE]);

  assign sysErr = |(sts & cmd);

  assert_ce_sets_R2: assert property (@(posedge clk) disable iff (!rstN)
    ceEvt |=> sts[BIT_CE]);
  assert_ue_sets_R2: assert property (@(posedge clk) disable iff (!rstN)
    ueEvt |=> sts[BIT_UE]);
  assert_w1c_R3: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && regSel == SEL_STS && wrData[BIT_TH] && !thEvt) |=> !sts[BIT_TH]);
  assert_event_wins_R4: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && regSel == SEL_STS && wrData[BIT_CE] && ceEvt) |=> sts[BIT_CE]);
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (sts[BIT_RT] && !(wrEn && regSel == SEL_STS && wrData[BIT_RT])) |=> sts[BIT_RT]);
endmodule

// File: rtl/ecc_log_datapath.sv
module ecc_log_datapath
  import ecc_log_pkg::*;
#(
  parameter int ADDR_W     = 33,
  parameter int GRAIN_BITS = 7,
  parameter int SYN_W      = 8,
  parameter int DATA_W     = 32
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  ctrlStrb_t                  strb,
  input  logic                       ueEvt,
  input  logic                       ceEvt,
  input  logic [ADDR_W-1:GRAIN_BITS] errLine,
  input  logic                       errChan,
  input  logic [SYN_W-1:0]           errSyn,
  input  logic [STS_W-1:0]           sts,
  input  logic [STS_W-1:0]           cmd,
  input  logic [2:0]                 regSel,
  output logic [DATA_W-1:0]          rdData
);
  logic [ADDR_W-1:GRAIN_BITS] logLine;
  logic                       logChan;
  logic [SYN_W-1:0]           logSyn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      logLine <= '0;
      logChan <= 1'b0;
      logSyn  <= '0;
    end else if (strb.logLoad) begin
      logLine <= errLine;
      logChan <= errChan;
      logSyn  <= errSyn;
    end
  end

  always_comb begin
    rdData = '0;
    case (regSel)
      SEL_STS: rdData[STS_W-1:0] = sts;
      SEL_CMD: rdData[STS_W-1:0] = cmd;
      SEL_PTR: rdData = {logLine[DATA_W-1:GRAIN_BITS], {(GRAIN_BITS-1){1'b0}}, logChan};
      SEL_EXT: rdData[0] = logLine[ADDR_W-1];
      SEL_SYN: rdData[SYN_W-1:0] = logSyn;
      default: rdData = '0;
    endcase
  end

  assert_ue_overwrite_R8: assert property (@(posedge clk) disable iff (!rstN)
    (ueEvt && !sts[BIT_UE]) |=> (logSyn == $past(errSyn) && logChan == $past(errChan)));
  assert_ue_frozen_R9: assert property (@(posedge clk) disable iff (!rstN)
    sts[BIT_UE] |=> ($stable(logSyn) && $stable(logLine)));
  assert_ce_frozen_R9: assert property (@(posedge clk) disable iff (!rstN)
    (sts[BIT_CE] && !ueEvt) |=> ($stable(logSyn) && $stable(logChan)));
  assert_first_ce_R7: assert property (@(posedge clk) disable iff (!rstN)
    (ceEvt && !ueEvt && sts[BIT_CE] == 1'b0 && sts[BIT_UE] == 1'b0)
      |=> logSyn == $past(errSyn));
endmodule

// File: rtl/ecc_err_log.sv
module ecc_err_log
  import ecc_log_pkg::*;
#(
  parameter int ADDR_W     = 33,
  parameter int GRAIN_BITS = 7,
  parameter int SYN_W      = 8,
  parameter int DATA_W     = 32
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       ceEvt,
  input  logic                       ueEvt,
  input  logic [ADDR_W-1:GRAIN_BITS] errLine,
  input  logic                       errChan,
  input  logic [SYN_W-1:0]           errSyn,
  input  logic                       refreshTimeout,
  input  logic                       lockNonDram,
  input  logic                       thermEvt,
  input  logic [2:0]                 regSel,
  input  logic                       regWrEn,
  input  logic [STS_W-1:0]           regWrData,
  output logic [DATA_W-1:0]          regRdData,
  output logic                       sysErr
);
  ctrlStrb_t        strb;
  logic [STS_W-1:0] sts;
  logic [STS_W-1:0] cmd;

  ecc_log_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .ceEvt  (ceEvt),
    .ueEvt  (ueEvt),
    .rtEvt  (refreshTimeout),
    .lkEvt  (lockNonDram),
    .thEvt  (thermEvt),
    .wrEn   (regWrEn),
    .regSel (regSel),
    .wrData (regWrData),
    .sts    (sts),
    .cmd    (cmd),
    .strb   (strb),
    .sysErr (sysErr)
  );

  ecc_log_datapath #(
    .ADDR_W     (ADDR_W),
    .GRAIN_BITS (GRAIN_BITS),
    .SYN_W      (SYN_W),
    .DATA_W     (DATA_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .ueEvt   (ueEvt),
    .ceEvt   (ceEvt),
    .errLine (errLine),
    .errChan (errChan),
    .errSyn  (errSyn),
    .sts     (sts),
    .cmd     (cmd),
    .regSel  (regSel),
    .rdData  (regRdData)
  );

  assert_syserr_R10: assert property (@(posedge clk) disable iff (!rstN)
    (sts[BIT_UE] && cmd[BIT_UE]) |-> sysErr);
  assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    (regSel == SEL_STS) |-> ((regRdData[15:0] & ~FLAG_MASK) == 16'h0 && regRdData[31:16] == 16'h0));
endmodule

// File: tb/test_ecc_err_log.sv
`timescale 1ns/100ps
module test_ecc_err_log;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ceEvt = 0, ueEvt = 0, errChan = 0;
  logic [32:7] errLine = '0;
  logic [7:0]  errSyn = '0;
  logic        refreshTimeout = 0, lockNonDram = 0, thermEvt = 0;
  logic [2:0]  regSel = '0;
  logic        regWrEn = 0;
  logic [15:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        sysErr;
  int          nChecks = 0;
  int          nFails = 0;
  bit          done = 0;

  always #2.5 clk = ~clk;

  ecc_err_log i_ecc_err_log (
    .clk(clk), .rstN(rstN), .ceEvt(ceEvt), .ueEvt(ueEvt), .errLine(errLine),
    .errChan(errChan), .errSyn(errSyn), .refreshTimeout(refreshTimeout),
    .lockNonDram(lockNonDram), .thermEvt(thermEvt), .regSel(regSel),
    .regWrEn(regWrEn), .regWrData(regWrData), .regRdData(regRdData), .sysErr(sysErr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] sel, input string req, input logic [31:0] exp);
    regSel = sel;
    #1;
    chk(req, regRdData, exp);
  endtask

  // Drive one cycle of stimulus: inputs set just after a falling edge,
  // captured at the following rising edge, released at the next fall.
  task automatic ecc(input logic ce, input logic ue, input logic [32:7] ln,
                     input logic ch, input logic [7:0] sy);
    @(negedge clk);
    ceEvt = ce; ueEvt = ue; errLine = ln; errChan = ch; errSyn = sy;
    @(negedge clk);
    ceEvt = 0; ueEvt = 0;
  endtask

  task automatic wr(input logic [2:0] sel, input logic [15:0] d);
    @(negedge clk);
    regSel = sel; regWrEn = 1; regWrData = d;
    @(negedge clk);
    regWrEn = 0;
  endtask

  task automatic other(input int pos);
    @(negedge clk);
    refreshTimeout = (pos == 8); lockNonDram = (pos == 9); thermEvt = (pos == 11);
    @(negedge clk);
    refreshTimeout = 0; lockNonDram = 0; thermEvt = 0;
  endtask

  function automatic logic [31:0] ptrOf(input logic [32:7] ln, input logic ch);
    return {ln[31:7], 6'd0, ch};
  endfunction

  task automatic chkLog(input string req, input logic [32:7] ln, input logic ch, input logic [7:0] sy);
    rd(3'd2, req, ptrOf(ln, ch));
    rd(3'd3, req, {31'd0, ln[32]});
    rd(3'd4, req, {24'd0, sy});
  endtask

  initial begin
    #100000;
    if (!done) begin
      nFails++; nChecks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    logic [32:7] a1, a2, a3;
    int flagPos [5];
    flagPos = '{0, 1, 8, 9, 11};
    a1 = 26'h2ABCDE1; a2 = 26'h1234567; a3 = 26'h3FFFFFF;
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1 reset state
    for (int s = 0; s < 8; s++) rd(s[2:0], "R1", 32'h0);
    chk("R1 sysErr", {31'd0, sysErr}, 32'h0);

    // R7 first CE logs; R2 flag at bit 0; R5/R6 layout
    ecc(1, 0, a1, 1, 8'h5A);
    rd(3'd0, "R2", 32'h0001);
    chkLog("R7 R5 R6", a1, 1, 8'h5A);
    // R9 CE while CE held
    ecc(1, 0, a2, 0, 8'h11);
    chkLog("R9", a1, 1, 8'h5A);
    // R8 UE overwrites pending CE
    ecc(0, 1, a2, 0, 8'hC3);
    rd(3'd0, "R2", 32'h0003);
    chkLog("R8", a2, 0, 8'hC3);
    // R9 CE and UE while UE held
    ecc(1, 0, a3, 1, 8'h77);
    chkLog("R9", a2, 0, 8'hC3);
    ecc(0, 1, a3, 1, 8'h88);
    chkLog("R9", a2, 0, 8'hC3);
    // R3 write-1-to-clear and write of 0
    wr(3'd0, 16'h0001);
    rd(3'd0, "R3", 32'h0002);
    wr(3'd0, 16'h0000);
    rd(3'd0, "R3", 32'h0002);
    // R9 UE flag alone still freezes log against CE
    ecc(1, 0, a1, 1, 8'h01);
    chkLog("R9", a2, 0, 8'hC3);
    wr(3'd0, 16'hFFFF);
    rd(3'd0, "R3", 32'h0000);
    // R11 writes to log registers ignored, unused select reads 0
    wr(3'd2, 16'hFFFF); wr(3'd3, 16'hFFFF); wr(3'd4, 16'hFFFF);
    chkLog("R11", a2, 0, 8'hC3);
    rd(3'd5, "R11", 32'h0);
    rd(3'd7, "R11", 32'h0);
    // R7 simultaneous CE and UE after clear: UE details taken
    ecc(1, 1, a3, 1, 8'h9E);
    rd(3'd0, "R7", 32'h0003);
    chkLog("R7", a3, 1, 8'h9E);
    wr(3'd0, 16'h0003);
    // R2 other flags, one at a time
    for (int i = 2; i < 5; i++) begin
      other(flagPos[i]);
      rd(3'd0, "R2", 32'(1) << flagPos[i]);
      wr(3'd0, 16'(1) << flagPos[i]);
      rd(3'd0, "R3", 32'h0);
    end
    // R4 clear collides with new event
    ecc(1, 0, a1, 0, 8'h22);
    @(negedge clk);
    regSel = 3'd0; regWrEn = 1; regWrData = 16'h0001; ceEvt = 1;
    @(negedge clk);
    regWrEn = 0; ceEvt = 0;
    rd(3'd0, "R4", 32'h0001);
    other(11);
    @(negedge clk);
    regSel = 3'd0; regWrEn = 1; regWrData = 16'h0800; thermEvt = 1;
    @(negedge clk);
    regWrEn = 0; thermEvt = 0;
    rd(3'd0, "R4", 32'h0801);
    wr(3'd0, 16'hFFFF);
    // R10 enable register storage
    wr(3'd1, 16'hFFFF);
    rd(3'd1, "R10", 32'h0B03);
    chk("R10 no flags", {31'd0, sysErr}, 32'h0);
    // R10 sweep: one flag set at a time, all 32 enable combinations
    for (int f = 0; f < 5; f++) begin
      if (f == 0) ecc(1, 0, a1, 0, 8'h00);
      else if (f == 1) ecc(0, 1, a1, 0, 8'h00);
      else other(flagPos[f]);
      for (int m = 0; m < 32; m++) begin
        logic [15:0] en;
        en = '0;
        for (int k = 0; k < 5; k++) if (m[k]) en[flagPos[k]] = 1'b1;
        wr(3'd1, en);
        #1;
        chk("R10 sysErr", {31'd0, sysErr}, {31'd0, m[f]});
      end
      wr(3'd0, 16'hFFFF);
      #1;
      chk("R10 cleared", {31'd0, sysErr}, 32'h0);
    end
    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule